// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block sits on the command side of a DRAM device model or protocol monitor. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins together with the bank and address pins, and turns them into a decoded command. It reports the addressed bank, the row and column fields, and the qualifier bits carried on the address lines. Address bit 10 means auto-precharge on a column access and all-bank close on a precharge. Address bit 12 requests a chopped burst on a column access.

For each of eight banks the block keeps an idle or active state and the row that was opened there. Each command is checked against that state. A command that is not legal for the current state raises an error flag and leaves every bank as it was. A clock-enable input freezes the block: once clock-enable has been sampled low, the next edge accepts no command, and the outputs and bank state hold their values.

All outputs are registered. A command sampled at an edge shows its result just after that same edge.

Top module: `dram_cmd_tracker`

## Requirements
- R1: While chip-select (`csN`) is sampled high, the command is decoded as no-operation (code 0), whatever the strobe pins carry, and no bank changes state.
- R2: With `csN` low, the pins {`rasN`,`casN`,`weN`} decode as follows: 011 activate (code 1), 010 precharge (code 2), 101 read (code 3), 100 write (code 4), 000 mode-register-set (code 5), 001 refresh (code 6). Both 111 and 110 decode as no-operation (code 0). The code appears on `cmdCode`.
- R3: An activate to an idle bank opens that bank and stores the 13-bit row taken from `addr`. `bankOut` shows the bank and `rowOut` shows that row.
- R4: A read or write to an active bank reports `colOut` = `addr[9:0]` and `rowOut` = the row stored for that bank. `chopOut` is high when `addr[12]` is low and low when `addr[12]` is high.
- R5: A read or write to an active bank with `addr[10]` high sets `autoPreOut` and leaves that bank idle after the command. With `addr[10]` low the bank stays open.
- R6: A precharge with `addr[10]` high closes all banks and sets `allBankOut`. With `addr[10]` low it closes only the addressed bank. A precharge to a bank that is already idle is legal and raises no error.
- R7: A read or write to an idle bank, an activate to an active bank, or a refresh while any bank is active sets `errOut`. No bank changes state. `rowOut`, `colOut`, `autoPreOut`, `allBankOut` and `chopOut` read 0, while `cmdCode` and `bankOut` still report the command.
- R8: If `clkEn` was sampled low at the previous rising edge, the current edge accepts no command. All outputs and the bank state hold their values. The edge at which `clkEn` is first sampled low still accepts its command.
- R9: During and after reset, every bank is idle and all outputs are 0 (no-operation, no error).
- R10: Results are registered. The outputs for a command sampled at a rising edge are valid from just after that edge until the next accepted edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock enable; a low sample freezes the next edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 3 | Bank index |
| addr | input | 13 | Row address / column address and qualifier bits |
| cmdCode | output | 3 | Decoded command code (see R2) |
| bankOut | output | 3 | Addressed bank, 0 for non-bank commands |
| rowOut | output | 13 | Opened row (activate) or open row of the bank (read/write) |
| colOut | output | 10 | Column address of a read or write |
| autoPreOut | output | 1 | Auto-precharge requested on a read or write |
| allBankOut | output | 1 | Precharge applies to all banks |
| chopOut | output | 1 | Chopped burst requested on a read or write |
| errOut | output | 1 | Command illegal for the current bank state |
| bankOpen | output | 8 | Active flag per bank |

## Verification
On every cycle, the assertions check these properties: an error never alters the bank state and zeroes the address fields; an accepted activate leaves its bank open; an auto-precharge access leaves its bank idle; an all-bank precharge empties the bank vector; and a frozen edge holds both state and outputs. Some behaviour is visible only in the bench's scenarios against its reference model. This covers the exact pin-to-code mapping, including the deselect and undefined patterns. It also covers the stored row returned by a later access, the chop polarity, and the rule that the first low clock-enable sample still accepts its command while the edge where clock-enable rises again does not.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_MRS = 3'd5,
    CMD_REF = 3'd6
  } cmd_e;

  // Strobes from control to datapath for one sampled edge
  typedef struct packed {
    logic accept;       // edge not frozen by clock enable
    cmd_e cmd;
    logic err;
    logic bankSel;      // report the bank index
    logic openBank;     // open addressed bank, store row
    logic closeBank;    // close addressed bank
    logic closeAll;     // close every bank
    logic useRowAddr;   // rowOut from address pins
    logic useStoredRow; // rowOut from stored open row
    logic useCol;       // colOut from address pins
    logic autoPre;
    logic allBank;
    logic chop;
  } strobe_t;

endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic                 apBit,
  input  logic                 bcBit,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              stb
);

  logic ckePrev;
  cmd_e cmdDec;
  logic bankIsOpen;
  logic anyOpen;

  // Clock enable sampled at the previous edge gates this edge
  always_ff @(posedge clk) begin
    if (!rstN) ckePrev <= 1'b1;
    else       ckePrev <= clkEn;
  end

  always_comb begin
    if (csN) begin
      cmdDec = CMD_NOP;
    end else begin
      unique case ({rasN, casN, weN})
        3'b011:  cmdDec = CMD_ACT;
        3'b010:  cmdDec = CMD_PRE;
        3'b101:  cmdDec = CMD_RD;
        3'b100:  cmdDec = CMD_WR;
        3'b000:  cmdDec = CMD_MRS;
        3'b001:  cmdDec = CMD_REF;
        default: cmdDec = CMD_NOP;
      endcase
    end
  end

  assign bankIsOpen = bankOpen[bankAddr];
  assign anyOpen    = |bankOpen;

  always_comb begin
    stb        = '0;
    stb.accept = ckePrev;
    stb.cmd    = cmdDec;
    unique case (cmdDec)
      CMD_ACT: begin
        stb.bankSel = 1'b1;
        if (bankIsOpen) begin
          stb.err = 1'b1;
        end else begin
          stb.openBank   = 1'b1;
          stb.useRowAddr = 1'b1;
        end
      end
      CMD_PRE: begin
        stb.bankSel = 1'b1;
        if (apBit) begin
          stb.closeAll = 1'b1;
          stb.allBank  = 1'b1;
        end else begin
          stb.closeBank = 1'b1;
        end
      end
      CMD_RD, CMD_WR: begin
        stb.bankSel = 1'b1;
        if (!bankIsOpen) begin
          stb.err = 1'b1;
        end else begin
          stb.useCol       = 1'b1;
          stb.useStoredRow = 1'b1;
          stb.autoPre      = apBit;
          stb.closeBank    = apBit;
          stb.chop         = ~bcBit;
        end
      end
      CMD_REF: begin
        stb.err = anyOpen;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ROW_W-1:0]     addr,
  output logic [2:0]           cmdOut,
  output logic [BANK_W-1:0]    bankOut,
  output logic [ROW_W-1:0]     rowOut,
  output logic [COL_W-1:0]     colOut,
  output logic                 autoPreOut,
  output logic                 allBankOut,
  output logic                 chopOut,
  output logic                 errOut,
  output logic [NUM_BANKS-1:0] bankOpen
);

  logic [NUM_BANKS-1:0][ROW_W-1:0] rowAll;
  logic [ROW_W-1:0]                rowNext;

  // Per-bank state: open flag and stored row
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openReg;
    logic [ROW_W-1:0] rowReg;
    logic             hit;

    assign hit = (bankAddr == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openReg <= 1'b0;
        rowReg  <= '0;
      end else if (stb.accept) begin
        if (stb.closeAll || (stb.closeBank && hit)) begin
          openReg <= 1'b0;
        end else if (stb.openBank && hit) begin
          openReg <= 1'b1;
          rowReg  <= addr;
        end
      end
    end

    assign bankOpen[b] = openReg;
    assign rowAll[b]   = rowReg;
  end

  always_comb begin
    if (stb.useRowAddr)        rowNext = addr;
    else if (stb.useStoredRow) rowNext = rowAll[bankAddr];
    else                       rowNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut     <= 3'd0;
      bankOut    <= '0;
      rowOut     <= '0;
      colOut     <= '0;
      autoPreOut <= 1'b0;
      allBankOut <= 1'b0;
      chopOut    <= 1'b0;
      errOut     <= 1'b0;
    end else if (stb.accept) begin
      cmdOut     <= stb.cmd;
      bankOut    <= stb.bankSel ? bankAddr : '0;
      rowOut     <= rowNext;
      colOut     <= stb.useCol ? addr[COL_W-1:0] : '0;
      autoPreOut <= stb.autoPre;
      allBankOut <= stb.allBank;
      chopOut    <= stb.chop;
      errOut     <= stb.err;
    end
  end

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  parameter int BC_BIT    = 12,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ROW_W-1:0]     addr,
  output logic [2:0]           cmdCode,
  output logic [BANK_W-1:0]    bankOut,
  output logic [ROW_W-1:0]     rowOut,
  output logic [COL_W-1:0]     colOut,
  output logic                 autoPreOut,
  output logic                 allBankOut,
  output logic                 chopOut,
  output logic                 errOut,
  output logic [NUM_BANKS-1:0] bankOpen
);

  strobe_t stb;

  dct_ctrl #(
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .bankAddr (bankAddr),
    .apBit    (addr[AP_BIT]),
    .bcBit    (addr[BC_BIT]),
    .bankOpen (bankOpen),
    .stb      (stb)
  );

  dct_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .bankAddr   (bankAddr),
    .addr       (addr),
    .cmdOut     (cmdCode),
    .bankOut    (bankOut),
    .rowOut     (rowOut),
    .colOut     (colOut),
    .autoPreOut (autoPreOut),
    .allBankOut (allBankOut),
    .chopOut    (chopOut),
    .errOut     (errOut),
    .bankOpen   (bankOpen)
  );

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clkEn,
  input logic [2:0]           cmdCode,
  input logic [BANK_W-1:0]    bankOut,
  input logic [ROW_W-1:0]     rowOut,
  input logic [COL_W-1:0]     colOut,
  input logic                 autoPreOut,
  input logic                 allBankOut,
  input logic                 chopOut,
  input logic                 errOut,
  input logic [NUM_BANKS-1:0] bankOpen
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R7: an illegal command leaves every bank unchanged
  a_r7_err_keeps_banks: assert property (@(posedge clk) disable iff (!rstN)
    (errOut && sinceRst != 2'd0) |-> (bankOpen == $past(bankOpen)));

  // R7: an illegal command reports no address fields or qualifiers
  a_r7_err_zero_fields: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (rowOut == '0 && colOut == '0 && !autoPreOut && !allBankOut && !chopOut));

  // R3: a legal activate leaves its bank open
  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 3'd1 && !errOut) |-> bankOpen[bankOut]);

  // R5: auto-precharge only on column access, and the bank ends idle
  a_r5_ap_closes: assert property (@(posedge clk) disable iff (!rstN)
    autoPreOut |-> (!bankOpen[bankOut] && (cmdCode == 3'd3 || cmdCode == 3'd4)));

  // R6: an all-bank precharge leaves no bank open
  a_r6_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    allBankOut |-> (bankOpen == '0 && cmdCode == 3'd2));

  // R4: burst chop only reported for reads and writes
  a_r4_chop_col_only: assert property (@(posedge clk) disable iff (!rstN)
    chopOut |-> (cmdCode == 3'd3 || cmdCode == 3'd4));

  // R8: an edge following a low clock-enable sample changes nothing
  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(clkEn, 2)) |->
      ($stable(bankOpen) && $stable(cmdCode) && $stable(rowOut) && $stable(errOut)));

endmodule

bind dram_cmd_tracker dct_checker #(
  .NUM_BANKS(NUM_BANKS),
  .ROW_W    (ROW_W),
  .COL_W    (COL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .cmdCode    (cmdCode),
  .bankOut    (bankOut),
  .rowOut     (rowOut),
  .colOut     (colOut),
  .autoPreOut (autoPreOut),
  .allBankOut (allBankOut),
  .chopOut    (chopOut),
  .errOut     (errOut),
  .bankOpen   (bankOpen)
);

// File: tb/dram_cmd_tracker_tb.sv
module dram_cmd_tracker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        csN = 1'b1;
  logic        rasN = 1'b1;
  logic        casN = 1'b1;
  logic        weN = 1'b1;
  logic [2:0]  bankAddr = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmdCode;
  logic [2:0]  bankOut;
  logic [12:0] rowOut;
  logic [9:0]  colOut;
  logic        autoPreOut, allBankOut, chopOut, errOut;
  logic [7:0]  bankOpen;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    int       cmd;
    int       bank;
    int       row;
    int       col;
    bit       ap;
    bit       all;
    bit       bc;
    bit       err;
    bit [7:0] open;
    string    tag;
  } exp_t;

  exp_t q[$];

  // Reference model state
  bit [7:0] mOpen = '0;
  int       mRow[8];
  bit       mCkePrev = 1'b1;
  exp_t     mLast;

  dram_cmd_tracker u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .bankAddr(bankAddr), .addr(addr),
    .cmdCode(cmdCode), .bankOut(bankOut), .rowOut(rowOut), .colOut(colOut),
    .autoPreOut(autoPreOut), .allBankOut(allBankOut), .chopOut(chopOut),
    .errOut(errOut), .bankOpen(bankOpen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic send(input bit cs, input bit ras, input bit cas, input bit we,
                      input int ba, input int a, input bit cke, input string tag);
    exp_t e;
    int   c;
    @(negedge clk);
    csN = cs; rasN = ras; casN = cas; weN = we;
    bankAddr = 3'(ba); addr = 13'(a); clkEn = cke;
    if (!mCkePrev) begin
      e = mLast;
      e.tag = tag;
    end else begin
      e.cmd = 0; e.bank = 0; e.row = 0; e.col = 0;
      e.ap = 0; e.all = 0; e.bc = 0; e.err = 0; e.tag = tag;
      if (cs) c = 0;
      else case ({ras, cas, we})
        3'b011: c = 1;
        3'b010: c = 2;
        3'b101: c = 3;
        3'b100: c = 4;
        3'b000: c = 5;
        3'b001: c = 6;
        default: c = 0;
      endcase
      e.cmd = c;
      case (c)
        1: begin
          e.bank = ba;
          if (mOpen[ba]) e.err = 1;
          else begin mOpen[ba] = 1; mRow[ba] = a; e.row = a; end
        end
        2: begin
          e.bank = ba;
          if (a[10]) begin mOpen = '0; e.all = 1; end
          else mOpen[ba] = 0;
        end
        3, 4: begin
          e.bank = ba;
          if (!mOpen[ba]) e.err = 1;
          else begin
            e.row = mRow[ba]; e.col = a & 1023;
            e.ap = a[10]; e.bc = !a[12];
            if (a[10]) mOpen[ba] = 0;
          end
        end
        6: if (mOpen != 0) e.err = 1;
        default: ;
      endcase
      e.open = mOpen;
      mLast = e;
    end
    mCkePrev = cke;
    q.push_back(e);
  endtask

  task automatic act(input int ba, input int row, input string tag);
    send(0, 0, 1, 1, ba, row, 1, tag);
  endtask

  task automatic col(input bit isWr, input int ba, input int c, input bit ap,
                     input bit noChop, input string tag);
    send(0, 1, 0, !isWr, ba, (c & 1023) | (ap << 10) | (noChop << 12), 1, tag);
  endtask

  task automatic pre(input int ba, input bit all, input string tag);
    send(0, 0, 1, 0, ba, all << 10, 1, tag);
  endtask

  // Monitor: one comparison per queued command, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(cmdCode) != e.cmd || int'(bankOut) != e.bank || int'(rowOut) != e.row ||
            int'(colOut) != e.col || autoPreOut != e.ap || allBankOut != e.all ||
            chopOut != e.bc || errOut != e.err || bankOpen != e.open) begin
          failures++;
          $display("FAIL %s: got cmd=%0d bank=%0d row=%h col=%h ap=%0b all=%0b bc=%0b err=%0b open=%b ; exp cmd=%0d bank=%0d row=%h col=%h ap=%0b all=%0b bc=%0b err=%0b open=%b",
                   e.tag, cmdCode, bankOut, rowOut, colOut, autoPreOut, allBankOut,
                   chopOut, errOut, bankOpen, e.cmd, e.bank, e.row, e.col, e.ap,
                   e.all, e.bc, e.err, e.open);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    checks++;
    if (cmdCode != 3'd0 || bankOpen != 8'd0 || errOut || rowOut != 0 || bankOut != 0) begin
      failures++;
      $display("FAIL R9: got cmd=%0d open=%b err=%0b, exp cmd=0 open=00000000 err=0",
               cmdCode, bankOpen, errOut);
    end

    send(0, 1, 1, 1, 0, 0, 1, "R2 nop");
    send(1, 0, 1, 1, 0, 13'h0555, 1, "R1 deselect masks activate");
    send(1, 1, 0, 0, 3, 0, 1, "R1 deselect masks write");
    act(2, 13'h1ABC, "R3 activate bank2");
    act(5, 13'h0123, "R3 activate bank5");
    col(0, 2, 10'h2A5, 0, 1, "R4 read full burst");
    col(1, 5, 10'h01F, 0, 0, "R4 write chopped");
    col(0, 3, 10'h011, 0, 1, "R7 read idle bank");
    act(2, 13'h0777, "R7 activate active bank");
    send(0, 0, 0, 1, 0, 0, 1, "R7 refresh with open bank");
    col(0, 5, 10'h3FF, 1, 0, "R5 read auto-precharge");
    col(1, 5, 10'h001, 0, 1, "R7 write after auto-precharge");
    col(1, 2, 10'h100, 0, 1, "R5 write without auto-precharge keeps open");
    pre(2, 0, "R6 precharge single");
    pre(4, 0, "R6 precharge idle bank legal");
    act(1, 13'h1FFF, "R3 activate bank1");
    act(7, 13'h0000, "R3 activate bank7");
    pre(3, 1, "R6 precharge all");
    send(0, 0, 0, 1, 0, 0, 1, "R2 refresh all idle");
    send(0, 0, 0, 0, 1, 13'h0042, 1, "R2 mode register set");
    send(0, 1, 1, 0, 0, 0, 1, "R2 undefined pattern as nop");
    // R8: freeze sequence
    send(0, 0, 1, 1, 4, 13'h0ABC, 0, "R8 first low sample accepted");
    send(0, 0, 1, 1, 6, 13'h0111, 0, "R8 frozen activate ignored");
    col(0, 4, 10'h055, 0, 1, "R8 edge after cke rises frozen");
    col(0, 4, 10'h066, 0, 1, "R8 accepted after thaw");
    act(6, 13'h0222, "R10 bank6 opens after freeze");
    col(1, 6, 10'h0AA, 1, 1, "R5 write auto-precharge bank6");
    send(0, 1, 1, 1, 0, 0, 1, "R10 trailing nop");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule